// File: doc/BRIEF.md
# Token Bucket Bandwidth Partitioner

This block sits between the per-core request sources of a multi-core chip and the shared off-chip request queue. Each core holds a bucket of tokens. One token stands for one 64-byte transfer. A request from a core, whether a demand miss or a prefetch, is forwarded only while that core's bucket is non-empty, and forwarding it spends one token. Otherwise the request stalls at the core, which holds it until it is granted. A common token generator steps once every `TICK_DIV` cycles. Across all cores together it hands out on average one token per step, split in proportion to per-core weights. The quota therefore bounds each core's share of off-chip transfers. The memory scheduler behind the queue keeps its own ordering.

The weights are refreshed at the end of every `WINDOW` cycles from activity counted during that window. For each core, `m` is the number of misses and `p` the number of prefetches issued. The product `m*(m+p)` equals miss rate × (miss rate + prefetch rate) × access frequency squared, because `m` already equals miss rate × access frequency. The weight is the integer cube root of that product. A sequential engine extracts the root one bit per cycle. The weights in force stay active until the engine has a full new set. The new set is then switched in at one edge.

A bypass input turns the quota off. Requests then contend freely, so each core gets its natural share, in proportion to its own request rate. At most one request is granted per cycle, in rotating priority order.

Top module: `tbp_partitioner`

## Requirements
- R1: After reset every bucket is empty, every accumulator is zero, rotation priority starts at core 0 and all weights are 1. With requests held high, no grant occurs during the first 12 cycles.
- R2: While `part_en` is 1, a core is granted only if its bucket holds at least one token, and each grant removes exactly one token from that core's bucket.
- R3: At most one bit of `req_gnt` is set in any cycle. The search for a grant starts at the core after the last one granted and wraps from core `NCORE-1` to core 0.
- R4: The generator steps once every `TICK_DIV` cycles. Each step adds weight `w[i]` to core i's accumulator. When the accumulator reaches the sum `S` of all weights, `S` is subtracted and one token is credited. Core i therefore gets `w[i]/S` tokens per step, and the cores together get one.
- R5: A bucket never grows beyond `cfg_depth`. A token credited to a full bucket is dropped.
- R6: Until the first recomputation completes, every core has weight 1, so token rates are equal.
- R7: At the end of each `WINDOW` cycles, core i's weight becomes floor(cbrt(m*(m+p))). Here `m` and `p` are that window's counts of `miss_evt[i]` and `pref_evt[i]` pulses, each held at its maximum rather than wrapping. Both counts then restart from zero.
- R8: The previous weights stay in force while the root engine runs. All new weights take effect at the same edge, and all accumulators are cleared at that edge. If every new weight is 0, every weight becomes 1.
- R9: While `part_en` is 0, buckets are not consulted, no tokens are spent, and any requesting core can be granted every cycle.
- R10: `req_gnt` responds combinationally to `req_vld` in the same cycle. An ungranted request must be held by its core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| part_en | input | 1 | 1 enforces quotas, 0 lets requests pass without quota |
| cfg_depth | input | DEPTH_W | Maximum tokens a bucket may hold |
| miss_evt | input | NCORE | One pulse per cache miss sent off-chip, per core |
| pref_evt | input | NCORE | One pulse per prefetch sent off-chip, per core |
| req_vld | input | NCORE | Pending off-chip request, per core |
| req_gnt | output | NCORE | One-hot grant: this core's request enters the shared queue |

## Verification
The hardest thing to reach from the ports is a committed set of unequal weights whose effect can be measured. Each weight exists only after a full counting window, and then only as a long-run token rate. The stimulus replays the same burst of miss and prefetch pulses at a fixed offset inside every window. The per-window counts are therefore exact, and every recomputation produces the same roots, including one non-perfect cube that exercises truncation. The bench then counts grants over a long interval with all requests held high. Rotation order is checked against a queue of expected cores after one single-core grant has set the priority pointer to a known value.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    // cube of an operand up to 16 bits wide
    function automatic logic [47:0] cube16(input logic [15:0] v);
        logic [47:0] w;
        w = {32'd0, v};
        return w * w * w;
    endfunction

endpackage

// File: rtl/tbp_rate_meter.sv
module tbp_rate_meter #(
    parameter int NCORE  = 4,
    parameter int CNT_W  = 12,
    parameter int WINDOW = 1000000,
    parameter int PROD_W = 2 * CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCORE-1:0]        miss_evt,
    input  logic [NCORE-1:0]        pref_evt,
    output logic [NCORE*PROD_W-1:0] prod_flat,
    output logic                    snap
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             win_end;

    assign win_end = (win_cnt == WIN_W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            snap    <= 1'b0;
        end else begin
            snap    <= win_end;
            win_cnt <= win_end ? '0 : win_cnt + WIN_W'(1);
        end
    end

    for (genvar i = 0; i < NCORE; i++) begin : g_cnt
        logic [CNT_W-1:0]  m_q;
        logic [CNT_W-1:0]  p_q;
        logic [CNT_W:0]    tot;
        logic [PROD_W-1:0] prod_q;

        assign tot = {1'b0, m_q} + {1'b0, p_q};
        assign prod_flat[i*PROD_W +: PROD_W] = prod_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q    <= '0;
                p_q    <= '0;
                prod_q <= '0;
            end else if (win_end) begin
                prod_q <= PROD_W'(m_q) * PROD_W'(tot);
                m_q    <= '0;
                p_q    <= '0;
            end else begin
                if (miss_evt[i] && (m_q != '1)) m_q <= m_q + CNT_W'(1);
                if (pref_evt[i] && (p_q != '1)) p_q <= p_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tbp_cbrt_seq.sv
module tbp_cbrt_seq
    import tbp_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int PROD_W = 25,
    parameter int RT_W   = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NCORE*PROD_W-1:0] prod_flat,
    output logic [NCORE*RT_W-1:0]   wt_flat,
    output logic                    commit
);
    localparam int IDX_W = $clog2(NCORE);
    localparam int BI_W  = $clog2(RT_W + 1);

    eng_state_e        state_q;
    logic [IDX_W-1:0]  ci_q;
    logic [BI_W-1:0]   bi_q;
    logic [RT_W-1:0]   root_q;
    logic [RT_W-1:0]   cand;
    logic [RT_W-1:0]   root_n;
    logic              fin_q;
    logic              any_nz;
    logic [PROD_W-1:0] x_q   [NCORE];
    logic [RT_W-1:0]   new_q [NCORE];
    logic [RT_W-1:0]   wt_q  [NCORE];

    assign cand   = root_q | (RT_W'(1) << bi_q);
    assign root_n = (cube16(16'(cand)) <= 48'(x_q[ci_q])) ? cand : root_q;
    assign commit = fin_q;

    always_comb begin
        any_nz = 1'b0;
        for (int k = 0; k < NCORE; k++) any_nz = any_nz | (new_q[k] != '0);
    end

    for (genvar k = 0; k < NCORE; k++) begin : g_out
        assign wt_flat[k*RT_W +: RT_W] = wt_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            ci_q    <= '0;
            bi_q    <= '0;
            root_q  <= '0;
            fin_q   <= 1'b0;
            for (int k = 0; k < NCORE; k++) begin
                x_q[k]   <= '0;
                new_q[k] <= '0;
                wt_q[k]  <= RT_W'(1);
            end
        end else begin
            fin_q <= 1'b0;
            if (fin_q) begin
                for (int k = 0; k < NCORE; k++)
                    wt_q[k] <= any_nz ? new_q[k] : RT_W'(1);
            end
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        for (int k = 0; k < NCORE; k++)
                            x_q[k] <= prod_flat[k*PROD_W +: PROD_W];
                        ci_q    <= '0;
                        bi_q    <= BI_W'(RT_W - 1);
                        root_q  <= '0;
                        state_q <= ENG_RUN;
                    end
                end
                default: begin
                    if (bi_q == '0) begin
                        new_q[ci_q] <= root_n;
                        root_q      <= '0;
                        bi_q        <= BI_W'(RT_W - 1);
                        if (ci_q == IDX_W'(NCORE - 1)) begin
                            state_q <= ENG_IDLE;
                            fin_q   <= 1'b1;
                        end else begin
                            ci_q <= ci_q + IDX_W'(1);
                        end
                    end else begin
                        root_q <= root_n;
                        bi_q   <= bi_q - BI_W'(1);
                    end
                end
            endcase
        end
    end

    AST_HOLD_OLD_SHARES: assert property (@(posedge clk) disable iff (rst)
        !fin_q |=> $stable(wt_flat)); // R8
endmodule

// File: rtl/tbp_bucket.sv
module tbp_bucket #(
    parameter int RT_W    = 9,
    parameter int SUM_W   = 12,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               clr,
    input  logic [RT_W-1:0]    wt,
    input  logic [SUM_W-1:0]   wsum,
    input  logic               take,
    input  logic [DEPTH_W-1:0] cfg_depth,
    output logic               has_tok
);
    logic [SUM_W-1:0]   acc_q;
    logic [SUM_W:0]     nxt;
    logic               credit;
    logic               gain;
    logic [DEPTH_W-1:0] cnt_q;

    assign nxt     = {1'b0, acc_q} + (SUM_W+1)'(wt);
    assign credit  = tick && (nxt >= {1'b0, wsum});
    assign gain    = credit && ((cnt_q < cfg_depth) || take);
    assign has_tok = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= credit ? SUM_W'(nxt - {1'b0, wsum}) : SUM_W'(nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (gain && !take) begin
            cnt_q <= cnt_q + DEPTH_W'(1);
        end else if (take && !gain) begin
            cnt_q <= cnt_q - DEPTH_W'(1);
        end
    end

    AST_TAKE_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt_q != '0)); // R2
    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > $past(cnt_q)) |-> (cnt_q <= cfg_depth)); // R5
endmodule

// File: rtl/tbp_partitioner.sv
module tbp_partitioner
    import tbp_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int WINDOW   = 1000000,
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 12,
    parameter int DEPTH_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               part_en,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [NCORE-1:0]   miss_evt,
    input  logic [NCORE-1:0]   pref_evt,
    input  logic [NCORE-1:0]   req_vld,
    output logic [NCORE-1:0]   req_gnt
);
    localparam int PROD_W = 2 * CNT_W + 1;
    localparam int RT_W   = (PROD_W + 2) / 3;
    localparam int IDX_W  = $clog2(NCORE);
    localparam int SUM_W  = RT_W + IDX_W + 1;
    localparam int TK_W   = $clog2(TICK_DIV + 1);

    logic [NCORE*PROD_W-1:0] prod_flat;
    logic [NCORE*RT_W-1:0]   wt_flat;
    logic                    snap;
    logic                    commit;
    logic [SUM_W-1:0]        wsum;
    logic [TK_W-1:0]         tk_q;
    logic                    tick;
    logic [NCORE-1:0]        tok_vec;
    logic [NCORE-1:0]        elig;
    logic [IDX_W-1:0]        rr_q;
    logic [IDX_W-1:0]        gidx;

    tbp_rate_meter #(.NCORE(NCORE), .CNT_W(CNT_W), .WINDOW(WINDOW), .PROD_W(PROD_W)) u_meter (
        .clk(clk), .rst(rst), .miss_evt(miss_evt), .pref_evt(pref_evt),
        .prod_flat(prod_flat), .snap(snap)
    );

    tbp_cbrt_seq #(.NCORE(NCORE), .PROD_W(PROD_W), .RT_W(RT_W)) u_root (
        .clk(clk), .rst(rst), .start(snap), .prod_flat(prod_flat),
        .wt_flat(wt_flat), .commit(commit)
    );

    assign tick = (tk_q == TK_W'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) tk_q <= '0;
        else     tk_q <= tick ? '0 : tk_q + TK_W'(1);
    end

    always_comb begin
        wsum = '0;
        for (int c = 0; c < NCORE; c++) wsum = wsum + SUM_W'(wt_flat[c*RT_W +: RT_W]);
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        tbp_bucket #(.RT_W(RT_W), .SUM_W(SUM_W), .DEPTH_W(DEPTH_W)) u_bkt (
            .clk(clk), .rst(rst), .tick(tick), .clr(commit),
            .wt(wt_flat[c*RT_W +: RT_W]), .wsum(wsum),
            .take(req_gnt[c] & part_en), .cfg_depth(cfg_depth),
            .has_tok(tok_vec[c])
        );
    end

    assign elig = req_vld & (part_en ? tok_vec : '1);

    always_comb begin
        req_gnt = '0;
        gidx    = '0;
        for (int off = 0; off < NCORE; off++) begin
            int k;
            k = int'(rr_q) + off;
            if (k >= NCORE) k = k - NCORE;
            if (elig[k] && (req_gnt == '0)) begin
                req_gnt[k] = 1'b1;
                gidx       = IDX_W'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rr_q <= '0;
        else if (req_gnt != '0)
            rr_q <= (gidx == IDX_W'(NCORE - 1)) ? '0 : gidx + IDX_W'(1);
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_gnt)); // R3
    AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (req_gnt & ~req_vld) == '0); // R10
    AST_BYPASS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!part_en && (req_vld != '0)) |-> (req_gnt != '0)); // R9
endmodule

// File: tb/tbp_partitioner_test.sv
module tbp_partitioner_test;
    localparam int NC  = 4;
    localparam int WIN = 256;
    localparam int TD  = 4;
    localparam int CW  = 12;
    localparam int DW  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          part_en;
    logic [DW-1:0] cfg_depth;
    logic [NC-1:0] miss_evt;
    logic [NC-1:0] pref_evt;
    logic [NC-1:0] req_vld;
    logic [NC-1:0] req_gnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit evt_on = 1'b0;
    bit sb_on = 1'b0;
    int gcount[NC];
    int exp_q[$];
    int mc[NC] = '{8, 3, 1, 4};
    int pc[NC] = '{0, 0, 2, 12};

    always #10 clk = ~clk;

    tbp_partitioner #(.NCORE(NC), .WINDOW(WIN), .TICK_DIV(TD), .CNT_W(CW), .DEPTH_W(DW)) uut (
        .clk(clk), .rst(rst), .part_en(part_en), .cfg_depth(cfg_depth),
        .miss_evt(miss_evt), .pref_evt(pref_evt), .req_vld(req_vld), .req_gnt(req_gnt)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // activity driver: same burst at offsets 20.. of every window
    always @(posedge clk) begin
        int o;
        #1;
        o = cyc % WIN;
        for (int i = 0; i < NC; i++) begin
            miss_evt[i] = evt_on && (o >= 20) && (o < 20 + mc[i]);
            pref_evt[i] = evt_on && (o >= 20) && (o < 20 + pc[i]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: counts grants and pops the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NC; i++) if (req_gnt[i]) gcount[i]++;
            if (sb_on && (req_gnt != '0)) begin
                int got;
                int e;
                got = 0;
                for (int i = 0; i < NC; i++) if (req_gnt[i]) got = i;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                chk(got == e, "R3 rotation order", got, e);
            end
        end
    end

    task automatic clr_counts();
        for (int i = 0; i < NC; i++) gcount[i] = 0;
    endtask

    task automatic wait_until(input int t);
        forever begin
            @(posedge clk);
            #2;
            if (cyc >= t) break;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int tot;
        int w[NC];
        rst = 1'b1; part_en = 1'b1; cfg_depth = DW'(3); req_vld = '0;
        miss_evt = '0; pref_evt = '0;
        clr_counts();
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        req_vld = '1;
        // R1: empty buckets after reset, nothing granted at first
        repeat (12) @(posedge clk);
        #2;
        tot = gcount[0] + gcount[1] + gcount[2] + gcount[3];
        chk(tot == 0, "R1 no grants before first token", tot, 0);

        // R6: equal weights before any recompute
        wait_until(40);
        clr_counts();
        wait_until(200);
        for (int i = 0; i < NC; i++)
            chk(gcount[i] >= 9 && gcount[i] <= 11, "R6 equal share", gcount[i], 10);
        tot = gcount[0] + gcount[1] + gcount[2] + gcount[3];
        chk(tot >= 38 && tot <= 42, "R4 one token per step in total", tot, 40);
        evt_on = 1'b1;

        // R8: window with no activity keeps equal weights
        wait_until(300);
        clr_counts();
        wait_until(500);
        for (int i = 0; i < NC; i++)
            chk(gcount[i] >= 11 && gcount[i] <= 14, "R8 all-zero falls back to equal", gcount[i], 12);

        // R7: weights 4,2,1,4 (sum 11) from m*(m+p) = 64,9,3,64
        w = '{4, 2, 1, 4};
        wait_until(600);
        clr_counts();
        wait_until(1040);
        for (int i = 0; i < NC; i++)
            chk(gcount[i] >= 10*w[i] - 2 && gcount[i] <= 10*w[i] + 1,
                "R7 cube-root weighted share", gcount[i], 10*w[i]);

        // R3/R10: fill buckets, pin the pointer, then check rotation
        req_vld = '0;
        wait_until(1540);
        req_vld = 4'b1000;
        @(negedge clk);
        chk(req_gnt == 4'b1000, "R10 same-cycle grant", int'(req_gnt), 8);
        @(posedge clk);
        #2;
        req_vld = '0;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < NC; i++) exp_q.push_back(i);
        sb_on = 1'b1;
        req_vld = '1;
        repeat (8) @(posedge clk);
        #2;
        req_vld = '0;
        sb_on = 1'b0;
        chk(exp_q.size() == 0, "R3 eight grants in eight cycles", exp_q.size(), 0);

        // R5: cap at depth 2
        cfg_depth = DW'(2);
        wait_until(2000);
        clr_counts();
        req_vld = 4'b0001;
        repeat (4) @(posedge clk);
        #2;
        chk(gcount[0] >= 2 && gcount[0] <= 3, "R5 burst limited by depth", gcount[0], 2);

        // R2: drained bucket, grants only at token rate (4/11 per step)
        clr_counts();
        repeat (88) @(posedge clk);
        #2;
        chk(gcount[0] >= 7 && gcount[0] <= 9, "R2 grants only with tokens", gcount[0], 8);
        req_vld = '0;

        // R9: bypass, a grant every cycle in rotation
        part_en = 1'b0;
        @(posedge clk);
        #2;
        clr_counts();
        req_vld = '1;
        repeat (20) @(posedge clk);
        #2;
        req_vld = '0;
        for (int i = 0; i < NC; i++)
            chk(gcount[i] == 5, "R9 bypass grants freely", gcount[i], 5);
        finish_run();
    end
endmodule